// File: doc/BRIEF.md
# Condition Register Update Unit

This block keeps a 32-bit condition register, organised as eight 4-bit fields, together with the three status bits of the fixed-point exception register: summary overflow, overflow and carry. An execution stage hands it one operation bundle per clock cycle. The bundle holds a valid strobe, an opcode, an 8-bit field mask, a 3-bit field index and a 32-bit source operand. The block then carries out one of three operations:

- a merged write of selected fields from the source operand;
- a copy of the exception status bits into one field, which also clears those bits;
- a read of the whole register onto a registered result bus.

Bits are numbered big-endian. Bit 0 is the most significant bit of the register, and field 0 sits in bits 0 to 3, which is `cr_out[31:28]`. Field-mask bit `fld_mask[7]` selects field 0, and `fld_mask[0]` selects field 7. The opcode carries one request flag per operation: `op_code[0]` asks for the masked write, `op_code[1]` for the status move and `op_code[2]` for the read. `op_code[3]` marks the code as unsupported. A separate write port lets an outside arithmetic unit load the three status bits. In `xer_wr_bits` and `xer_out`, bit 2 is SO, bit 1 is OV and bit 0 is CA.

Top module: `cond_reg_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the register, the status bits, `res_valid` and `res_data` become zero at that edge.
- R2: An accepted masked write sets the register to (source AND mask) OR (old AND NOT mask). The mask repeats each field-mask bit four times, and `fld_mask[i]` covers `cr_out[4*i+3:4*i]`.
- R3: An accepted status move writes {SO, OV, CA, 0} into field k. Field k is `cr_out[31-4*k : 28-4*k]`, and k is `fld_idx`. All other fields keep their value.
- R4: After an accepted status move, `xer_out` is 3'b000, even when `xer_wr_en` is high in the same cycle.
- R5: An accepted read raises `res_valid` for one cycle, with `res_data` equal to the register value from before that edge. The register is not changed.
- R6: When several request flags are set together, only one is accepted. The masked write goes first, then the move, then the read. A request that is not accepted clears no status bits and produces no result.
- R7: With `op_valid` low, or with `op_code[3]` set, the register does not change, no result is produced, and the status bits change only through the outside write port.
- R8: When no status move is accepted and `xer_wr_en` is high, `xer_out` takes the value of `xer_wr_bits` at the next edge.
- R9: `res_valid` is low in every cycle that does not follow an accepted read, and `res_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation bundle valid |
| op_code | input | 4 | [0] masked write, [1] status move, [2] read, [3] unsupported |
| fld_mask | input | 8 | Per-field write select, bit 7 selects field 0 |
| fld_idx | input | 3 | Target field of the status move |
| src_data | input | 32 | Source operand for the masked write |
| xer_wr_en | input | 1 | Outside status write enable |
| xer_wr_bits | input | 3 | Outside status value {SO, OV, CA} |
| res_valid | output | 1 | Read result valid |
| res_data | output | 32 | Read result |
| cr_out | output | 32 | Current condition register |
| xer_out | output | 3 | Current status bits {SO, OV, CA} |

## Verification
The hardest case to reach from the ports is a status move that lands in the same cycle as an outside status write. The clear has to win over the load. The move that is lost to a concurrent masked write is hard for the same reason, because in that case the outside load has to win. The stimulus builds both cases directly: the status bits are first loaded to a non-zero value, and then the combined bundle is issued with `xer_wr_en` high. A long pseudo-random run then mixes every combination of request flags, the unsupported marker, outside writes and occasional resets. The run is compared against a behavioural model on every clock.

// File: rtl/cru_pkg.sv
package cru_pkg;
  parameter int FLD_W_DEF   = 4;
  parameter int NUM_FLD_DEF = 8;
  parameter int STAT_W      = 3;
  parameter int OPC_W       = 4;

  localparam int OPC_WRITE = 0;
  localparam int OPC_MOVE  = 1;
  localparam int OPC_READ  = 2;
  localparam int OPC_UNSUP = 3;

  typedef enum logic [1:0] {
    GR_NONE  = 2'd0,
    GR_WRITE = 2'd1,
    GR_MOVE  = 2'd2,
    GR_READ  = 2'd3
  } grant_e;
endpackage

// File: rtl/cru_arbiter.sv
module cru_arbiter
  import cru_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  output grant_e           grant
);
  always_comb begin
    grant = GR_NONE;
    if (op_valid && !op_code[OPC_UNSUP]) begin
      if (op_code[OPC_WRITE])     grant = GR_WRITE;
      else if (op_code[OPC_MOVE]) grant = GR_MOVE;
      else if (op_code[OPC_READ]) grant = GR_READ;
    end
  end
endmodule

// File: rtl/cru_mask_expand.sv
module cru_mask_expand #(
  parameter int FLD_W   = 4,
  parameter int NUM_FLD = 8,
  localparam int CR_W   = FLD_W * NUM_FLD
) (
  input  logic [NUM_FLD-1:0] fld_mask,
  output logic [CR_W-1:0]    bit_mask
);
  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign bit_mask[i*FLD_W +: FLD_W] = {FLD_W{fld_mask[i]}};
  end
endmodule

// File: rtl/cru_field_insert.sv
module cru_field_insert #(
  parameter int FLD_W   = 4,
  parameter int NUM_FLD = 8,
  localparam int CR_W   = FLD_W * NUM_FLD,
  localparam int IDX_W  = $clog2(NUM_FLD)
) (
  input  logic [CR_W-1:0]  cr_in,
  input  logic [IDX_W-1:0] idx,
  input  logic [FLD_W-1:0] nibble,
  output logic [CR_W-1:0]  cr_ins
);
  // Field 0 is the most significant field (big-endian numbering).
  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    localparam logic [IDX_W-1:0] SEL = IDX_W'(NUM_FLD - 1 - i);
    assign cr_ins[i*FLD_W +: FLD_W] = (idx == SEL) ? nibble : cr_in[i*FLD_W +: FLD_W];
  end
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
  import cru_pkg::*;
#(
  parameter int FLD_W   = FLD_W_DEF,
  parameter int NUM_FLD = NUM_FLD_DEF,
  localparam int CR_W   = FLD_W * NUM_FLD,
  localparam int IDX_W  = $clog2(NUM_FLD)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [OPC_W-1:0]   op_code,
  input  logic [NUM_FLD-1:0] fld_mask,
  input  logic [IDX_W-1:0]   fld_idx,
  input  logic [CR_W-1:0]    src_data,
  input  logic               xer_wr_en,
  input  logic [STAT_W-1:0]  xer_wr_bits,
  output logic               res_valid,
  output logic [CR_W-1:0]    res_data,
  output logic [CR_W-1:0]    cr_out,
  output logic [STAT_W-1:0]  xer_out
);
  grant_e             grant;
  logic [CR_W-1:0]    bit_mask;
  logic [CR_W-1:0]    cr_ins;
  logic [FLD_W-1:0]   move_nib;
  logic [CR_W-1:0]    cr_q, cr_nxt;
  logic [STAT_W-1:0]  xer_q, xer_nxt;

  cru_arbiter u_arb (
    .op_valid (op_valid),
    .op_code  (op_code),
    .grant    (grant)
  );

  cru_mask_expand #(.FLD_W(FLD_W), .NUM_FLD(NUM_FLD)) u_mask (
    .fld_mask (fld_mask),
    .bit_mask (bit_mask)
  );

  // {SO, OV, CA} land in the top bits of the field, the rest is zero.
  assign move_nib = FLD_W'(xer_q) << (FLD_W - STAT_W);

  cru_field_insert #(.FLD_W(FLD_W), .NUM_FLD(NUM_FLD)) u_ins (
    .cr_in  (cr_q),
    .idx    (fld_idx),
    .nibble (move_nib),
    .cr_ins (cr_ins)
  );

  always_comb begin
    unique case (grant)
      GR_WRITE: cr_nxt = (src_data & bit_mask) | (cr_q & ~bit_mask);
      GR_MOVE:  cr_nxt = cr_ins;
      default:  cr_nxt = cr_q;
    endcase
  end

  always_comb begin
    if (grant == GR_MOVE) xer_nxt = '0;
    else if (xer_wr_en)   xer_nxt = xer_wr_bits;
    else                  xer_nxt = xer_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q      <= '0;
      xer_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      cr_q      <= cr_nxt;
      xer_q     <= xer_nxt;
      res_valid <= (grant == GR_READ);
      if (grant == GR_READ) res_data <= cr_q;
    end
  end

  assign cr_out  = cr_q;
  assign xer_out = xer_q;
endmodule

// File: rtl/cru_chk.sv
module cru_chk
  import cru_pkg::*;
#(
  parameter int FLD_W   = FLD_W_DEF,
  parameter int NUM_FLD = NUM_FLD_DEF,
  localparam int CR_W   = FLD_W * NUM_FLD,
  localparam int IDX_W  = $clog2(NUM_FLD)
) (
  input logic               clk,
  input logic               rst,
  input logic               op_valid,
  input logic [OPC_W-1:0]   op_code,
  input logic [NUM_FLD-1:0] fld_mask,
  input logic [IDX_W-1:0]   fld_idx,
  input logic [CR_W-1:0]    src_data,
  input logic               xer_wr_en,
  input logic [STAT_W-1:0]  xer_wr_bits,
  input logic               res_valid,
  input logic [CR_W-1:0]    res_data,
  input logic [CR_W-1:0]    cr_out,
  input logic [STAT_W-1:0]  xer_out
);
  logic legal, acc_wr, acc_mv, acc_rd;
  assign legal  = op_valid && !op_code[OPC_UNSUP];
  assign acc_wr = legal && op_code[OPC_WRITE];
  assign acc_mv = legal && !op_code[OPC_WRITE] && op_code[OPC_MOVE];
  assign acc_rd = legal && !op_code[OPC_WRITE] && !op_code[OPC_MOVE] && op_code[OPC_READ];

  assert_move_clears_R4: assert property (@(posedge clk) disable iff (rst)
    acc_mv |=> (xer_out == '0));

  assert_read_result_R5: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> (res_valid && res_data == $past(cr_out) && $stable(cr_out)));

  assert_losing_move_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && op_code[OPC_MOVE] && !xer_wr_en) |=> $stable(xer_out));

  assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (rst)
    (!legal && !xer_wr_en) |=> ($stable(cr_out) && $stable(xer_out) && !res_valid));

  assert_alu_load_R8: assert property (@(posedge clk) disable iff (rst)
    (xer_wr_en && !acc_mv) |=> (xer_out == $past(xer_wr_bits)));

  assert_no_stray_result_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> (!res_valid && $stable(res_data)));
endmodule

bind cond_reg_unit cru_chk #(.FLD_W(FLD_W), .NUM_FLD(NUM_FLD)) u_chk (.*);

// File: tb/cond_reg_unit_tb_top.sv
`timescale 1ns/1ps
module cond_reg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [7:0]  fld_mask;
  logic [2:0]  fld_idx;
  logic [31:0] src_data;
  logic        xer_wr_en;
  logic [2:0]  xer_wr_bits;
  logic        res_valid;
  logic [31:0] res_data;
  logic [31:0] cr_out;
  logic [2:0]  xer_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_cr;
  logic [2:0]  m_xer;
  logic        m_rv;
  logic [31:0] m_rd;

  always #4 clk = ~clk;

  cond_reg_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .fld_mask(fld_mask), .fld_idx(fld_idx), .src_data(src_data),
    .xer_wr_en(xer_wr_en), .xer_wr_bits(xer_wr_bits),
    .res_valid(res_valid), .res_data(res_data),
    .cr_out(cr_out), .xer_out(xer_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle; the model predicts the state after the next rising edge.
  task automatic step(input string req, input logic r, input logic v, input logic [3:0] c,
                      input logic [7:0] m, input logic [2:0] k, input logic [31:0] s,
                      input logic we, input logic [2:0] wb);
    @(negedge clk);
    rst = r; op_valid = v; op_code = c; fld_mask = m; fld_idx = k;
    src_data = s; xer_wr_en = we; xer_wr_bits = wb;
    if (r) begin
      m_cr = 0; m_xer = 0; m_rv = 0; m_rd = 0;
    end else begin
      int sel = 0; // 0 none, 1 write, 2 move, 3 read
      if (v && !c[3]) begin
        if (c[0]) sel = 1;
        else if (c[1]) sel = 2;
        else if (c[2]) sel = 3;
      end
      m_rv = (sel == 3);
      if (sel == 3) m_rd = m_cr;
      if (sel == 1)
        for (int i = 0; i < 8; i++) if (m[i]) m_cr[4*i +: 4] = s[4*i +: 4];
      if (sel == 2) begin
        m_cr[28 - 4*k +: 4] = {m_xer, 1'b0};
        m_xer = 3'b000;
      end else if (we) m_xer = wb;
    end
    @(posedge clk);
    #1;
    check({req, " cr"},   cr_out,  m_cr);
    check({req, " xer"},  32'(xer_out), 32'(m_xer));
    check({req, " rv"},   32'(res_valid), 32'(m_rv));
    check({req, " rd"},   res_data, m_rd);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; op_valid = 0; op_code = 0; fld_mask = 0; fld_idx = 0;
    src_data = 0; xer_wr_en = 0; xer_wr_bits = 0;
    m_cr = 0; m_xer = 0; m_rv = 0; m_rd = 0;
    step("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1 reset", 1, 1, 4'b0001, 8'hFF, 0, 32'hFFFF_FFFF, 1, 3'b111);
    // R2 masked writes
    step("R2 full", 0, 1, 4'b0001, 8'hFF, 0, 32'hDEAD_BEEF, 0, 0);
    step("R2 field0 only", 0, 1, 4'b0001, 8'h80, 0, 32'h1234_5678, 0, 0);
    step("R2 field7 only", 0, 1, 4'b0001, 8'h01, 0, 32'h0000_000A, 0, 0);
    step("R2 no fields", 0, 1, 4'b0001, 8'h00, 0, 32'h5555_5555, 0, 0);
    step("R2 alternate", 0, 1, 4'b0001, 8'h5A, 0, 32'hA5A5_A5A5, 0, 0);
    // R8 outside load, R3/R4 move
    step("R8 load", 0, 0, 0, 0, 0, 0, 1, 3'b101);
    step("R3 move f0", 0, 1, 4'b0010, 0, 3'd0, 0, 0, 0);
    step("R8 load", 0, 0, 0, 0, 0, 0, 1, 3'b111);
    step("R4 move f7 vs load", 0, 1, 4'b0010, 0, 3'd7, 0, 1, 3'b010);
    step("R8 load", 0, 0, 0, 0, 0, 0, 1, 3'b011);
    step("R3 move f3", 0, 1, 4'b0010, 0, 3'd3, 0, 0, 0);
    // R5 read
    step("R5 read", 0, 1, 4'b0100, 0, 0, 0, 0, 0);
    step("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 priority
    step("R8 load", 0, 0, 0, 0, 0, 0, 1, 3'b110);
    step("R6 all three", 0, 1, 4'b0111, 8'h0F, 3'd2, 32'h0BAD_F00D, 0, 0);
    step("R6 write+move load", 0, 1, 4'b0011, 8'hF0, 3'd1, 32'h7777_0000, 1, 3'b001);
    step("R6 move+read", 0, 1, 4'b0110, 0, 3'd5, 0, 0, 0);
    step("R6 read after", 0, 1, 4'b0100, 0, 0, 0, 0, 0);
    // R7 ignored bundles
    step("R8 load", 0, 0, 0, 0, 0, 0, 1, 3'b111);
    step("R7 unsupported", 0, 1, 4'b1111, 8'hFF, 3'd4, 32'hFFFF_FFFF, 0, 0);
    step("R7 not valid", 0, 0, 4'b0011, 8'hFF, 3'd4, 32'h0, 0, 0);
    step("R7 unsup with load", 0, 1, 4'b1010, 0, 3'd0, 0, 1, 3'b010);
    step("R5 read back", 0, 1, 4'b0100, 0, 0, 0, 0, 0);
    // mixed pseudo-random run
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      step("R2-mix", (b[7:0] == 8'd3), b[8], b[12:9], a[7:0], a[10:8], $urandom,
           b[13], b[16:14]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule